// File: doc/BRIEF.md
# Carry-Select Compound Adder

This combinational adder takes two unsigned operands of equal width and delivers two results together: the plain sum A+B and the incremented sum A+B+1. Each result comes with its own carry-out. Consumers of both values include rounding logic, which picks one of the two after a late decision, and comparators that need a value and its successor.

The operand is divided into segments. Every segment holds a pair of ripple-carry adders, one built with an incoming carry of 0 and one built with an incoming carry of 1. Two independent select chains run across the segments. The plain-sum chain starts from the lowest segment's carry-0 adder. The incremented chain starts from the lowest segment's carry-1 adder.

In every higher segment, each chain uses the carry that the same chain chose one segment below. That carry selects between the segment's carry-0 and carry-1 results. A compile-time parameter sets the segmentation:

- Mode 0 uses one segment across the full width. This is the default.
- Mode 1 cuts the operand into 4-bit segments. The lowest segment is narrowed to hold the leftover bits.

A second width parameter for operand B must match the operand width, or elaboration stops.

Top module: `csca_compound_adder`

## Requirements
- R1: `{sum_co, sum}` equals the zero-extended A plus the zero-extended B, with a width of OP_W+1 bits.
- R2: `{inc_co, inc}` equals A+B+1, with a width of OP_W+1 bits.
- R3: When A+B is all ones in OP_W bits with no carry-out, `inc` is all zeros and `inc_co` is 1.
- R4: With SPLIT=0 (single full-width segment), R1 and R2 hold for every input pair.
- R5: With SPLIT=1 and OP_W above 4, the segments are 4 bits wide and the lowest segment holds OP_W mod 4 bits when that remainder is not zero. R1 and R2 hold for widths that are not multiples of 4.
- R6: With SPLIT=1 and OP_W of 4 or less, a single segment is used and R1 and R2 still hold.
- R7: `{inc_co, inc}` is always exactly one more than `{sum_co, sum}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | OP_W | First unsigned operand |
| b | input | B_W | Second unsigned operand; B_W must equal OP_W |
| sum | output | OP_W | Low bits of A+B |
| sum_co | output | 1 | Carry-out of A+B |
| inc | output | OP_W | Low bits of A+B+1 |
| inc_co | output | 1 | Carry-out of A+B+1 |

## Verification
The bench builds seven copies of the adder:

| Width | SPLIT | Segments | Inputs |
|---|---|---|---|
| 4 | 1 | one (forced) | exhaustive |
| 5 | 1 | 1+4 | exhaustive |
| 6 | 1 | 2+4 | exhaustive |
| 7 | 0 | one | exhaustive |
| 13 | 1 | 1+4+4+4 | random |
| 37 | 0 | one | random |
| 64 | 1 | sixteen | random |

The exhaustive sweeps reach every carry crossing between segments, for both chains. The wide copies exercise long chains of selects, including carries that run the full width, through all-ones corner operands.

// File: rtl/csca_pkg.sv
package csca_pkg;

  localparam int SEG_BITS = 4;

  typedef enum int {
    SPLIT_SINGLE = 0,
    SPLIT_NIBBLE = 1
  } split_mode_e;

  function automatic int seg_count(input int width, input int split);
    if (split == int'(SPLIT_SINGLE) || width <= SEG_BITS) return 1;
    return (width + SEG_BITS - 1) / SEG_BITS;
  endfunction

  function automatic int seg_first_width(input int width, input int split);
    return width - SEG_BITS * (seg_count(width, split) - 1);
  endfunction

  function automatic int seg_width(input int width, input int split, input int idx);
    if (idx == 0) return seg_first_width(width, split);
    return SEG_BITS;
  endfunction

  function automatic int seg_lsb(input int width, input int split, input int idx);
    if (idx == 0) return 0;
    return seg_first_width(width, split) + SEG_BITS * (idx - 1);
  endfunction

endpackage

// File: rtl/csca_ripple.sv
module csca_ripple #(
  parameter int  W   = 4,
  parameter bit  CIN = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] c;

  assign c[0] = CIN;

  for (genvar k = 0; k < W; k++) begin : g_bit
    logic p;
    assign p      = a[k] ^ b[k];
    assign s[k]   = p ^ c[k];
    assign c[k+1] = (a[k] & b[k]) | (p & c[k]);
  end

  assign co = c[W];

endmodule

// File: rtl/csca_segment.sv
module csca_segment #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s_c0,
  output logic         co_c0,
  output logic [W-1:0] s_c1,
  output logic         co_c1
);

  csca_ripple #(.W(W), .CIN(1'b0)) u_rc0 (
    .a (a),
    .b (b),
    .s (s_c0),
    .co(co_c0)
  );

  csca_ripple #(.W(W), .CIN(1'b1)) u_rc1 (
    .a (a),
    .b (b),
    .s (s_c1),
    .co(co_c1)
  );

endmodule

// File: rtl/csca_select.sv
module csca_select #(
  parameter int W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] s_c0,
  input  logic         co_c0,
  input  logic [W-1:0] s_c1,
  input  logic         co_c1,
  output logic [W-1:0] s,
  output logic         co
);

  always_comb begin
    if (sel) begin
      s  = s_c1;
      co = co_c1;
    end else begin
      s  = s_c0;
      co = co_c0;
    end
  end

endmodule

// File: rtl/csca_compound_adder.sv
module csca_compound_adder #(
  parameter int OP_W  = 16,
  parameter int B_W   = OP_W,
  parameter int SPLIT = 0
) (
  input  logic [OP_W-1:0] a,
  input  logic [B_W-1:0]  b,
  output logic [OP_W-1:0] sum,
  output logic            sum_co,
  output logic [OP_W-1:0] inc,
  output logic            inc_co
);

  localparam int NSEG = csca_pkg::seg_count(OP_W, SPLIT);

  if (B_W != OP_W) begin : g_width_mismatch
    $error("csca_compound_adder: operand widths differ");
  end
  if (OP_W < 1 || OP_W > 64) begin : g_width_range
    $error("csca_compound_adder: OP_W must lie in 1..64");
  end
  if (SPLIT != 0 && SPLIT != 1) begin : g_split_range
    $error("csca_compound_adder: SPLIT must be 0 or 1");
  end

  logic [NSEG-1:0] sum_cy;
  logic [NSEG-1:0] inc_cy;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int SW  = csca_pkg::seg_width(OP_W, SPLIT, i);
    localparam int LSB = csca_pkg::seg_lsb(OP_W, SPLIT, i);

    logic [SW-1:0] s_c0, s_c1;
    logic          co_c0, co_c1;

    csca_segment #(.W(SW)) u_seg (
      .a    (a[LSB +: SW]),
      .b    (b[LSB +: SW]),
      .s_c0 (s_c0),
      .co_c0(co_c0),
      .s_c1 (s_c1),
      .co_c1(co_c1)
    );

    if (i == 0) begin : g_head
      assign sum[LSB +: SW] = s_c0;
      assign sum_cy[i]      = co_c0;
      assign inc[LSB +: SW] = s_c1;
      assign inc_cy[i]      = co_c1;
    end else begin : g_link
      csca_select #(.W(SW)) u_sel_sum (
        .sel  (sum_cy[i-1]),
        .s_c0 (s_c0),
        .co_c0(co_c0),
        .s_c1 (s_c1),
        .co_c1(co_c1),
        .s    (sum[LSB +: SW]),
        .co   (sum_cy[i])
      );
      csca_select #(.W(SW)) u_sel_inc (
        .sel  (inc_cy[i-1]),
        .s_c0 (s_c0),
        .co_c0(co_c0),
        .s_c1 (s_c1),
        .co_c1(co_c1),
        .s    (inc[LSB +: SW]),
        .co   (inc_cy[i])
      );
    end
  end

  assign sum_co = sum_cy[NSEG-1];
  assign inc_co = inc_cy[NSEG-1];

endmodule

// File: rtl/csca_checker.sv
module csca_checker #(
  parameter int OP_W = 16
) (
  input logic [OP_W-1:0] a,
  input logic [OP_W-1:0] b,
  input logic [OP_W-1:0] sum,
  input logic            sum_co,
  input logic [OP_W-1:0] inc,
  input logic            inc_co
);

  localparam logic [OP_W:0] ONE_X  = (OP_W+1)'(1);
  localparam logic [OP_W:0] ALL1_X = {1'b0, {OP_W{1'b1}}};

  logic [OP_W:0] ref_sum;
  logic [OP_W:0] got_sum;
  logic [OP_W:0] got_inc;

  assign ref_sum = {1'b0, a} + {1'b0, b};
  assign got_sum = {sum_co, sum};
  assign got_inc = {inc_co, inc};

  always_comb begin
    assert_sum_R1: assert (got_sum == ref_sum)
      else $error("sum mismatch (R1)");
    assert_inc_R2: assert (got_inc == ref_sum + ONE_X)
      else $error("incremented sum mismatch (R2)");
    if (ref_sum == ALL1_X) begin
      assert_wrap_R3: assert (inc == '0 && inc_co)
        else $error("incremented sum did not wrap (R3)");
    end
    assert_pair_R7: assert (got_inc == got_sum + ONE_X)
      else $error("results not one apart (R7)");
  end

endmodule

bind csca_compound_adder csca_checker #(.OP_W(OP_W)) u_chk (
  .a     (a),
  .b     (b),
  .sum   (sum),
  .sum_co(sum_co),
  .inc   (inc),
  .inc_co(inc_co)
);

// File: tb/sim_csca_compound_adder.sv
`timescale 1ns/1ps
module sim_csca_compound_adder;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  logic [5:0]  a0, b0, s0, i0;   logic c0s, c0i;
  logic [6:0]  a1, b1, s1, i1;   logic c1s, c1i;
  logic [4:0]  a2, b2, s2, i2;   logic c2s, c2i;
  logic [3:0]  a3, b3, s3, i3;   logic c3s, c3i;
  logic [63:0] a4, b4, s4, i4;   logic c4s, c4i;
  logic [36:0] a5, b5, s5, i5;   logic c5s, c5i;
  logic [12:0] a6, b6, s6, i6;   logic c6s, c6i;

  csca_compound_adder #(.OP_W(6),  .SPLIT(1)) u0 (.a(a0), .b(b0), .sum(s0), .sum_co(c0s), .inc(i0), .inc_co(c0i));
  csca_compound_adder #(.OP_W(7),  .SPLIT(0)) u1 (.a(a1), .b(b1), .sum(s1), .sum_co(c1s), .inc(i1), .inc_co(c1i));
  csca_compound_adder #(.OP_W(5),  .SPLIT(1)) u2 (.a(a2), .b(b2), .sum(s2), .sum_co(c2s), .inc(i2), .inc_co(c2i));
  csca_compound_adder #(.OP_W(4),  .SPLIT(1)) u3 (.a(a3), .b(b3), .sum(s3), .sum_co(c3s), .inc(i3), .inc_co(c3i));
  csca_compound_adder #(.OP_W(64), .SPLIT(1)) u4 (.a(a4), .b(b4), .sum(s4), .sum_co(c4s), .inc(i4), .inc_co(c4i));
  csca_compound_adder #(.OP_W(37), .SPLIT(0)) u5 (.a(a5), .b(b5), .sum(s5), .sum_co(c5s), .inc(i5), .inc_co(c5i));
  csca_compound_adder #(.OP_W(13), .SPLIT(1)) u6 (.a(a6), .b(b6), .sum(s6), .sum_co(c6s), .inc(i6), .inc_co(c6i));

  task automatic chk(input string who, input string rq, input logic [64:0] got,
                     input logic [64:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", rq, who, got, exp);
    end
  endtask

  // R1/R2 always; mode requirement tag rq; R3 and R7 when they apply
  task automatic chk_pair(input string who, input string rq, input int w,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [64:0] gs, input logic [64:0] gi);
    logic [64:0] es, ei, all1;
    es   = {1'b0, a} + {1'b0, b};
    ei   = es + 65'd1;
    all1 = (65'd1 << w) - 65'd1;
    chk({who, " sum"}, {"R1 ", rq}, gs, es);
    chk({who, " inc"}, {"R2 ", rq}, gi, ei);
    chk({who, " gap"}, "R7", gi - gs, 65'd1);
    if (es == all1) chk({who, " wrap"}, "R3", gi, 65'd1 << w);
  endtask

  task automatic check_all;
    chk_pair("u0", "R5", 6,  64'(a0), 64'(b0), 65'({c0s, s0}), 65'({c0i, i0}));
    chk_pair("u1", "R4", 7,  64'(a1), 64'(b1), 65'({c1s, s1}), 65'({c1i, i1}));
    chk_pair("u2", "R5", 5,  64'(a2), 64'(b2), 65'({c2s, s2}), 65'({c2i, i2}));
    chk_pair("u3", "R6", 4,  64'(a3), 64'(b3), 65'({c3s, s3}), 65'({c3i, i3}));
    chk_pair("u4", "R5", 64, a4,      b4,      65'({c4s, s4}), 65'({c4i, i4}));
    chk_pair("u5", "R4", 37, 64'(a5), 64'(b5), 65'({c5s, s5}), 65'({c5i, i5}));
    chk_pair("u6", "R5", 13, 64'(a6), 64'(b6), 65'({c6s, s6}), 65'({c6i, i6}));
  endtask

  task automatic drive_all(input logic [63:0] x, input logic [63:0] y);
    a0 = x[5:0];  b0 = y[5:0];
    a1 = x[6:0];  b1 = y[6:0];
    a2 = x[4:0];  b2 = y[4:0];
    a3 = x[3:0];  b3 = y[3:0];
    a4 = x;       b4 = y;
    a5 = x[36:0]; b5 = y[36:0];
    a6 = x[12:0]; b6 = y[12:0];
  endtask

  task automatic step_check;
    @(negedge clk);
    check_all();
    @(posedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    drive_all('0, '0);
    @(posedge clk);
    // Zero operands: sum 0, incremented 1
    step_check();

    // Corner operands: all ones plus zero (R3 wrap), all ones plus all ones, one plus all ones
    drive_all('1, '0);               step_check();
    drive_all('0, '1);               step_check();
    drive_all('1, '1);               step_check();
    drive_all(64'd1, '1);            step_check();
    drive_all(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA); step_check();
    drive_all(64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0); step_check();
    drive_all(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000); step_check();

    // Exhaustive sweep for the small copies, random values for the wide ones
    for (int i = 0; i < 16384; i++) begin
      logic [63:0] rx, ry;
      rx = {$urandom(), $urandom()};
      ry = {$urandom(), $urandom()};
      a0 = i[11:6]; b0 = i[5:0];
      a1 = i[13:7]; b1 = i[6:0];
      a2 = i[9:5];  b2 = i[4:0];
      a3 = i[7:4];  b3 = i[3:0];
      a4 = rx;       b4 = ry;
      a5 = rx[36:0]; b5 = ry[36:0];
      a6 = rx[12:0]; b6 = ry[12:0];
      if (i % 8 == 0) b4 = ~rx;
      if (i % 8 == 1) b5 = ~rx[36:0];
      if (i % 8 == 2) b6 = ~rx[12:0];
      step_check();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule